// File: doc/BRIEF.md
# Quadruple Row Activation Random Block Sequencer

This block sits on the controller side of a DRAM-like array and turns deliberately mistimed row commands into raw random bits. Each round writes four neighbouring rows of one bank with conflicting data. It then fires an activate, precharge, activate burst whose spacing is shorter than the legal minimums, so that all four rows open together and the sense amplifiers settle to unpredictable values. The resulting block is read back column by column.

A table of per-bitline entropy weights is loaded before use. The sequencer walks the captured block bitline by bitline and keeps the bits whose weight is non-zero. It adds up their weights until the total reaches the requested number of entropy bits. Kept bits are XOR-folded into an output word whose width equals the post-processing input. If one block is not rich enough, the whole write, activate and read round is repeated and accumulation carries on. A one-cycle done pulse marks the word as ready. An abort input closes the bank and returns to idle.

Top module: `qrs_quad_seq`

## Requirements
- R1: After an accepted start, rows base, base+1, base+2 and base+3 of the latched bank are written in ascending order. Each row gets ACT (code 1), then one WR (code 3) per column in ascending column order, then PRE (code 2). The data is all ones for the two lower rows and all zeros for the two upper rows.
- R2: After the four writes comes ACT to row base, then PRE, then ACT to row base+3. The PRE follows the first ACT by the act-to-pre gap register (tm_sel 0), and the second ACT follows the PRE by the pre-to-act gap register (tm_sel 1). Both gaps are counted in clock cycles, reset to 1, and a written value of 0 acts as 1.
- R3: The first RD (code 4) is issued exactly as many cycles after the second ACT as the settle register holds (tm_sel 2, reset value 10, 0 acts as 1). RDs then go out on consecutive cycles for columns 0 to NCOLS-1 in ascending order. Once all NCOLS data beats are back, a PRE closes the bank.
- R4: Bit j of the k-th returned beat of a round is bitline k*DW+j. Bitlines are examined in ascending index order.
- R5: A bitline whose weight (entry of the table at its index, 255 meaning one full bit) is zero is never kept. A kept bitline adds its weight to the entropy total.
- R6: Selection stops as soon as the total reaches ENT_BITS*255. The i-th kept bit of the request (counting from 0 across rounds) is XORed into output bit i mod OUT_W. The output word is cleared when a start is accepted.
- R7: When a block has been fully examined below the target, the sequencer runs another round from R1 and keeps accumulating.
- R8: Each completed request raises done_o for exactly one cycle. rn_o keeps its value until the next accepted start.
- R9: A start that arrives while a request is in progress has no effect on the command stream or on the result.
- R10: An abort while busy makes the next command a PRE to the latched bank. The sequencer then idles with no done pulse, and a later start runs a fresh request.
- R11: Out of reset the command bus shows NOP (code 0), done_o is low and rn_o is zero. Weights and timing registers are written through their own write ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one random word (taken only when idle) |
| abort_i | input | 1 | Close the bank and return to idle |
| base_row_i | input | RW | Lowest of the four rows, latched at start |
| bank_i | input | BW | Bank used, latched at start |
| done_o | output | 1 | One-cycle pulse: rn_o holds a finished word |
| rn_o | output | OUT_W | Folded random word for post-processing |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 PRE, 3 WR, 4 RD |
| bank_o | output | BW | Command bank |
| row_o | output | RW | Row for ACT and WR |
| col_o | output | CW | Column for WR and RD |
| wdata_o | output | DW | Write data |
| rdata_i | input | DW | Read data beat |
| rvalid_i | input | 1 | Read data beat valid |
| wt_we_i | input | 1 | Weight table write enable |
| wt_idx_i | input | BLW | Bitline index to write |
| wt_val_i | input | 8 | Weight, 255 = one bit of entropy |
| tm_we_i | input | 1 | Timing register write enable |
| tm_sel_i | input | 2 | 0 act-to-pre gap, 1 pre-to-act gap, 2 settle |
| tm_val_i | input | TW | Timing register value in cycles |

## Verification
The bench builds the sequencer with four columns of eight bits, a 16-bit output word and a 16-bit entropy target, so a block has 32 bitlines and the target is 4080 weight units. At that size a uniform weight of 128 on even bitlines only, or 64 on every bitline, forces a second round. The 64-weight case also wraps the fold pointer four times within a few hundred cycles. Short gaps and settle values, including zero, can be checked cycle by cycle against the command bus.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_WR  = 3'd3,
    CMD_RD  = 3'd4
  } qrs_cmd_e;

  // weight value meaning one full bit of entropy
  localparam int unsigned WUNIT = 255;

  // entropy goal in weight units
  function automatic int unsigned target_units(input int unsigned ebits);
    return ebits * WUNIT;
  endfunction

  // R1: the two lower rows of the quad hold ones
  function automatic logic row_is_ones(input logic [1:0] off);
    return (off < 2'd2);
  endfunction

  // R2/R3: programmed cycle count, zero treated as one
  function automatic int unsigned eff_cycles(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/qrs_wtab.sv
module qrs_wtab #(
  parameter int unsigned NBL = 512,
  parameter int unsigned WW  = 8,
  localparam int unsigned BLW = $clog2(NBL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [BLW-1:0] widx_i,
  input  logic [WW-1:0]  wval_i,
  input  logic [BLW-1:0] ridx_i,
  output logic [WW-1:0]  rval_o
);

  logic [WW-1:0] tab [NBL];

  for (genvar g = 0; g < NBL; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  tab[g] <= '0;
      else if (we_i && (widx_i == BLW'(g)))        tab[g] <= wval_i;
    end
  end

  assign rval_o = tab[ridx_i];

endmodule

// File: rtl/qrs_tregs.sv
module qrs_tregs import qrs_pkg::*; #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [TW-1:0] val_i,
  output logic [TW-1:0] gap_ap_o,
  output logic [TW-1:0] gap_pa_o,
  output logic [TW-1:0] settle_o
);

  logic [TW-1:0] ap_q, pa_q, st_q;

  // R2/R3: reset values 1, 1 and 10 cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_q <= TW'(1);
      pa_q <= TW'(1);
      st_q <= TW'(10);
    end else if (we_i) begin
      case (sel_i)
        2'd0:    ap_q <= val_i;
        2'd1:    pa_q <= val_i;
        2'd2:    st_q <= val_i;
        default: ;
      endcase
    end
  end

  assign gap_ap_o = TW'(eff_cycles(int'(ap_q)));
  assign gap_pa_o = TW'(eff_cycles(int'(pa_q)));
  assign settle_o = TW'(eff_cycles(int'(st_q)));

endmodule

// File: rtl/qrs_harvest.sv
module qrs_harvest import qrs_pkg::*; #(
  parameter int unsigned NCOLS    = 8,
  parameter int unsigned DW       = 64,
  parameter int unsigned OUT_W    = 256,
  parameter int unsigned ENT_BITS = 256,
  localparam int unsigned NBL   = NCOLS * DW,
  localparam int unsigned BLW   = $clog2(NBL),
  localparam int unsigned BCW   = $clog2(NCOLS + 1),
  localparam int unsigned PW    = (OUT_W > 1) ? $clog2(OUT_W) : 1,
  localparam int unsigned TGT   = target_units(ENT_BITS),
  localparam int unsigned ACC_W = $clog2(TGT + 256) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             blk_clr_i,
  input  logic             cap_v_i,
  input  logic [DW-1:0]    cap_d_i,
  output logic             all_beats_o,
  input  logic             scan_go_i,
  output logic             scan_done_o,
  output logic             enough_o,
  output logic [BLW-1:0]   wt_idx_o,
  input  logic [7:0]       wt_val_i,
  output logic [OUT_W-1:0] rn_o
);

  logic [NBL-1:0]   blk;
  logic [BCW-1:0]   beat_cnt;
  logic             scanning;
  logic [BLW-1:0]   idx;
  logic [PW-1:0]    pos;
  logic [ACC_W-1:0] acc;
  logic [OUT_W-1:0] rn_q;
  logic             done_q;

  // named events for the checks below
  logic             cap_fire;
  logic             sel_fire;
  logic             last_bl;
  logic [ACC_W-1:0] acc_nx;
  logic             cur_bit;

  function automatic logic [PW-1:0] next_pos(input logic [PW-1:0] p);
    if (int'(p) == OUT_W - 1) return '0;
    return p + PW'(1);
  endfunction

  assign cap_fire = cap_v_i && (int'(beat_cnt) < NCOLS);
  assign all_beats_o = (int'(beat_cnt) == NCOLS);

  // R4: beat k lands on bitlines k*DW .. k*DW+DW-1
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   blk[c*DW +: DW] <= '0;
      else if (cap_fire && (beat_cnt == BCW'(c)))   blk[c*DW +: DW] <= cap_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          beat_cnt <= '0;
    else if (blk_clr_i)  beat_cnt <= '0;
    else if (cap_fire)   beat_cnt <= beat_cnt + BCW'(1);
  end

  assign enough_o = (acc >= ACC_W'(TGT));
  assign wt_idx_o = idx;
  assign cur_bit  = blk[idx];
  assign sel_fire = scanning && (wt_val_i != 8'd0) && !enough_o;  // R5
  assign acc_nx   = acc + ACC_W'(wt_val_i);
  assign last_bl  = (idx == BLW'(NBL - 1));

  // R5/R6: one bitline per cycle, fold kept bits into rn
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning <= 1'b0;
      idx      <= '0;
      pos      <= '0;
      acc      <= '0;
      rn_q     <= '0;
      done_q   <= 1'b0;
    end else if (clr_i) begin
      scanning <= 1'b0;
      idx      <= '0;
      pos      <= '0;
      acc      <= '0;
      rn_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (scan_go_i) begin
        scanning <= 1'b1;
        idx      <= '0;
      end else if (scanning) begin
        if (sel_fire) begin
          rn_q[pos] <= rn_q[pos] ^ cur_bit;
          pos       <= next_pos(pos);
          acc       <= acc_nx;
        end
        if (last_bl || (sel_fire && (acc_nx >= ACC_W'(TGT)))) begin
          scanning <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx <= idx + BLW'(1);
        end
      end
    end
  end

  assign scan_done_o = done_q;
  assign rn_o        = rn_q;

  p_zero_weight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && (wt_val_i == 8'd0) && !clr_i && !scan_go_i) |=> ($stable(acc) && $stable(rn_q)));

  p_acc_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (acc >= $past(acc)));

  p_hold_after_goal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enough_o && !clr_i) |=> $stable(rn_q));

endmodule

// File: rtl/qrs_quad_seq.sv
module qrs_quad_seq import qrs_pkg::*; #(
  parameter int unsigned NCOLS    = 8,
  parameter int unsigned DW       = 64,
  parameter int unsigned OUT_W    = 256,
  parameter int unsigned ENT_BITS = 256,
  parameter int unsigned RW       = 16,
  parameter int unsigned BW       = 3,
  parameter int unsigned TW       = 8,
  localparam int unsigned NBL = NCOLS * DW,
  localparam int unsigned BLW = $clog2(NBL),
  localparam int unsigned CW  = (NCOLS > 1) ? $clog2(NCOLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [RW-1:0]    base_row_i,
  input  logic [BW-1:0]    bank_i,
  output logic             done_o,
  output logic [OUT_W-1:0] rn_o,
  output logic [2:0]       cmd_o,
  output logic [BW-1:0]    bank_o,
  output logic [RW-1:0]    row_o,
  output logic [CW-1:0]    col_o,
  output logic [DW-1:0]    wdata_o,
  input  logic [DW-1:0]    rdata_i,
  input  logic             rvalid_i,
  input  logic             wt_we_i,
  input  logic [BLW-1:0]   wt_idx_i,
  input  logic [7:0]       wt_val_i,
  input  logic             tm_we_i,
  input  logic [1:0]       tm_sel_i,
  input  logic [TW-1:0]    tm_val_i
);

  typedef enum logic [3:0] {
    S_IDLE, S_IACT, S_IWR, S_IPRE, S_QACT1, S_QGAP1, S_QGAP2,
    S_SETTLE, S_RD, S_RWAIT, S_CLOSE, S_SCAN, S_DONE, S_ABORT
  } st_e;

  st_e           st;
  logic [1:0]    ri;
  logic [CW-1:0] col;
  logic [TW-1:0] cnt;
  logic [RW-1:0] base_q;
  logic [BW-1:0] bank_q;
  qrs_cmd_e      cmd_e;

  logic [TW-1:0]    gap_ap, gap_pa, settle;
  logic             all_beats, scan_done, enough;
  logic [BLW-1:0]   h_idx;
  logic [7:0]       h_w;

  // named events
  logic busy;
  logic req_take;
  logic scan_go;
  logic blk_clr;
  logic ev_qact2;

  assign busy     = (st != S_IDLE) && (st != S_ABORT);
  assign req_take = (st == S_IDLE) && start_i && !abort_i;  // R9: only when idle
  assign scan_go  = (st == S_CLOSE);
  assign blk_clr  = (st == S_QACT1);
  assign ev_qact2 = (st == S_QGAP2) && (cnt == '0);

  qrs_tregs #(.TW(TW)) u_tregs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (tm_we_i),
    .sel_i    (tm_sel_i),
    .val_i    (tm_val_i),
    .gap_ap_o (gap_ap),
    .gap_pa_o (gap_pa),
    .settle_o (settle)
  );

  qrs_wtab #(.NBL(NBL), .WW(8)) u_wtab (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (wt_we_i),
    .widx_i (wt_idx_i),
    .wval_i (wt_val_i),
    .ridx_i (h_idx),
    .rval_o (h_w)
  );

  qrs_harvest #(
    .NCOLS(NCOLS), .DW(DW), .OUT_W(OUT_W), .ENT_BITS(ENT_BITS)
  ) u_harv (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (req_take),
    .blk_clr_i   (blk_clr),
    .cap_v_i     (rvalid_i),
    .cap_d_i     (rdata_i),
    .all_beats_o (all_beats),
    .scan_go_i   (scan_go),
    .scan_done_o (scan_done),
    .enough_o    (enough),
    .wt_idx_o    (h_idx),
    .wt_val_i    (h_w),
    .rn_o        (rn_o)
  );

  // round sequence: init rows, quad activation, read, harvest (R1, R2, R3, R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ri     <= '0;
      col    <= '0;
      cnt    <= '0;
      base_q <= '0;
      bank_q <= '0;
    end else if (abort_i && busy) begin
      st <= S_ABORT;                                   // R10
    end else begin
      unique case (st)
        S_IDLE: if (req_take) begin
          st     <= S_IACT;
          ri     <= '0;
          base_q <= base_row_i;
          bank_q <= bank_i;
        end
        S_IACT: begin
          st  <= S_IWR;
          col <= '0;
        end
        S_IWR: begin
          if (col == CW'(NCOLS - 1)) st <= S_IPRE;
          else                       col <= col + CW'(1);
        end
        S_IPRE: begin
          if (ri == 2'd3) st <= S_QACT1;
          else begin
            ri <= ri + 2'd1;
            st <= S_IACT;
          end
        end
        S_QACT1: begin
          cnt <= gap_ap - TW'(1);
          st  <= S_QGAP1;
        end
        S_QGAP1: begin
          if (cnt == '0) begin
            cnt <= gap_pa - TW'(1);
            st  <= S_QGAP2;
          end else cnt <= cnt - TW'(1);
        end
        S_QGAP2: begin
          if (cnt == '0) begin
            cnt <= settle - TW'(1);
            st  <= S_SETTLE;
          end else cnt <= cnt - TW'(1);
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            col <= CW'(1);
            st  <= (NCOLS == 1) ? S_RWAIT : S_RD;
          end else cnt <= cnt - TW'(1);
        end
        S_RD: begin
          if (col == CW'(NCOLS - 1)) st <= S_RWAIT;
          else                       col <= col + CW'(1);
        end
        S_RWAIT: if (all_beats) st <= S_CLOSE;
        S_CLOSE: st <= S_SCAN;
        S_SCAN: if (scan_done) begin
          ri <= '0;
          st <= enough ? S_DONE : S_IACT;
        end
        S_DONE:  st <= S_IDLE;
        S_ABORT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_e   = CMD_NOP;
    row_o   = base_q;
    col_o   = col;
    wdata_o = '0;
    unique case (st)
      S_IACT: begin
        cmd_e = CMD_ACT;
        row_o = base_q + RW'(ri);
      end
      S_IWR: begin
        cmd_e   = CMD_WR;
        row_o   = base_q + RW'(ri);
        wdata_o = row_is_ones(ri) ? {DW{1'b1}} : {DW{1'b0}};
      end
      S_IPRE:  cmd_e = CMD_PRE;
      S_QACT1: cmd_e = CMD_ACT;
      S_QGAP1: if (cnt == '0) cmd_e = CMD_PRE;
      S_QGAP2: if (cnt == '0) begin
        cmd_e = CMD_ACT;
        row_o = base_q + RW'(3);
      end
      S_SETTLE: if (cnt == '0) begin
        cmd_e = CMD_RD;
        col_o = '0;
      end
      S_RD:    cmd_e = CMD_RD;
      S_CLOSE: cmd_e = CMD_PRE;
      S_ABORT: cmd_e = CMD_PRE;
      default: ;
    endcase
  end

  assign cmd_o  = cmd_e;
  assign bank_o = bank_q;
  assign done_o = (st == S_DONE);

  p_done_needs_goal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> enough);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_wr_pattern_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'(CMD_WR)) |-> ((row_o - base_q < RW'(2)) ? (wdata_o == {DW{1'b1}})
                                                         : (wdata_o == {DW{1'b0}})));

  p_abort_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && busy) |=> (cmd_o == 3'(CMD_PRE)));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(base_q) && $stable(bank_q)));

  p_settle_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_qact2 |=> (st == S_SETTLE));

endmodule

// File: tb/test_qrs_quad_seq.sv
`timescale 1ns/1ps
module test_qrs_quad_seq;

  localparam int NC = 4, DWB = 8, OW = 16, EB = 16, RWB = 8, BWB = 2, TWB = 8;
  localparam int NB = NC * DWB;
  localparam int GOAL = EB * 255;
  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_PRE = 3'd2, K_WR = 3'd3, K_RD = 3'd4;
  localparam logic [RWB-1:0] BASE = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0;
  logic [RWB-1:0] base_row_i = BASE;
  logic [BWB-1:0] bank_i = 2'd2;
  logic done_o;
  logic [OW-1:0] rn_o;
  logic [2:0] cmd_o;
  logic [BWB-1:0] bank_o;
  logic [RWB-1:0] row_o;
  logic [1:0] col_o;
  logic [DWB-1:0] wdata_o, rdata_i = '0;
  logic rvalid_i = 1'b0;
  logic wt_we_i = 1'b0;
  logic [4:0] wt_idx_i = '0;
  logic [7:0] wt_val_i = '0;
  logic tm_we_i = 1'b0;
  logic [1:0] tm_sel_i = '0;
  logic [TWB-1:0] tm_val_i = '0;

  always #4 clk = ~clk;

  qrs_quad_seq #(.NCOLS(NC), .DW(DWB), .OUT_W(OW), .ENT_BITS(EB),
                 .RW(RWB), .BW(BWB), .TW(TWB)) i_qrs_quad_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .base_row_i(base_row_i), .bank_i(bank_i), .done_o(done_o), .rn_o(rn_o),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .wdata_o(wdata_o), .rdata_i(rdata_i), .rvalid_i(rvalid_i),
    .wt_we_i(wt_we_i), .wt_idx_i(wt_idx_i), .wt_val_i(wt_val_i),
    .tm_we_i(tm_we_i), .tm_sel_i(tm_sel_i), .tm_val_i(tm_val_i));

  int n_tests = 0, n_fail = 0;
  longint cyc = 0;
  logic [7:0] wmem [NB];
  int e_g1 = 1, e_g2 = 1, e_st = 10;

  // reference model and monitor state
  logic [OW-1:0] exp_rn;
  int exp_pos, exp_acc, exp_beat;
  int act_idx, wr_cnt, wr_col, rd_col, rounds, done_cnt;
  longint last_act_t, pre_t, act_before_t;
  int last_act_row;
  logic [2:0] prev_cmd;
  bit d0, d1;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_act_row(input int k);
    case (k % 6)
      0: return 0; 1: return 1; 2: return 2; 3: return 3; 4: return 0;
      default: return 3;
    endcase
  endfunction

  task automatic model_clear();
    exp_rn = '0; exp_pos = 0; exp_acc = 0; exp_beat = 0;
    act_idx = 0; wr_cnt = 0; wr_col = 0; rd_col = 0; rounds = 0; done_cnt = 0;
    prev_cmd = K_NOP;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_o == K_ACT) begin
        // R1 rows base..base+3, R2 quad rows base then base+3
        chk(int'(row_o) - int'(BASE) == exp_act_row(act_idx),
            (act_idx % 6) < 4 ? "R1 act row" : "R2 act row",
            int'(row_o) - int'(BASE), exp_act_row(act_idx));
        act_idx++;
        last_act_t = cyc; last_act_row = int'(row_o); wr_col = 0;
      end
      if (cmd_o == K_PRE) begin
        act_before_t = last_act_t; pre_t = cyc;
      end
      if (cmd_o == K_WR) begin
        chk(wdata_o == ((last_act_row - int'(BASE) < 2) ? 8'hFF : 8'h00), "R1 data",
            wdata_o, (last_act_row - int'(BASE) < 2) ? 8'hFF : 8'h00);
        chk(int'(col_o) == wr_col, "R1 wr col", col_o, wr_col);
        wr_col++; wr_cnt++;
      end
      if (cmd_o == K_RD) begin
        if (prev_cmd != K_RD) begin
          chk(cyc - last_act_t == e_st, "R3 settle", cyc - last_act_t, e_st);
          chk(last_act_t - pre_t == e_g2, "R2 pre-act gap", last_act_t - pre_t, e_g2);
          chk(pre_t - act_before_t == e_g1, "R2 act-pre gap", pre_t - act_before_t, e_g1);
          chk(wr_cnt == 4 * NC, "R1 write count", wr_cnt, 4 * NC);
          wr_cnt = 0; rd_col = 0; rounds++; exp_beat = 0;
        end
        chk(int'(col_o) == rd_col, "R3 rd col", col_o, rd_col);
        rd_col++;
      end
      if (done_o) done_cnt++;
      prev_cmd = cmd_o;
      // memory: data two cycles after RD; R4 R5 R6 reference
      rvalid_i = d1;
      if (d1) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        rdata_i = lfsr[7:0] ^ lfsr[15:8];
        for (int j = 0; j < DWB; j++) begin
          int bl;
          bl = exp_beat * DWB + j;
          if (exp_acc < GOAL && wmem[bl] != 8'd0) begin
            exp_rn[exp_pos] = exp_rn[exp_pos] ^ rdata_i[j];
            exp_pos = (exp_pos + 1) % OW;
            exp_acc = exp_acc + int'(wmem[bl]);
          end
        end
        exp_beat++;
      end
      d1 = d0;
      d0 = (cmd_o == K_RD);
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic load_weights(input int mode);
    for (int i = 0; i < NB; i++) begin
      case (mode)
        0: wmem[i] = 8'd255;
        1: wmem[i] = (i % 2 == 0) ? 8'd128 : 8'd0;
        default: wmem[i] = 8'd64;
      endcase
      @(negedge clk);
      wt_we_i = 1'b1; wt_idx_i = 5'(i); wt_val_i = wmem[i];
    end
    @(negedge clk); wt_we_i = 1'b0;
  endtask

  task automatic set_tm(input int g1, input int g2, input int st);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      tm_we_i = 1'b1; tm_sel_i = 2'(s);
      tm_val_i = TWB'(s == 0 ? g1 : (s == 1 ? g2 : st));
    end
    @(negedge clk); tm_we_i = 1'b0;
    e_g1 = (g1 == 0) ? 1 : g1; e_g2 = (g2 == 0) ? 1 : g2; e_st = (st == 0) ? 1 : st;
  endtask

  // start a request; optional second start at cycle poke (R9)
  task automatic run_req(input string nm, input int exp_rounds, input int poke);
    bit got;
    got = 1'b0;
    model_clear();
    @(negedge clk); start_i = 1'b1;
    for (int i = 1; i < 4000 && !got; i++) begin
      @(negedge clk);
      start_i = (i == poke);
      if (done_o) got = 1'b1;
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(got, {nm, " R8 done seen"}, got, 1);
    chk(done_cnt == 1, {nm, " R8 single done"}, done_cnt, 1);
    chk(rn_o == exp_rn, {nm, " R4 R6 word"}, rn_o, exp_rn);
    chk(rounds == exp_rounds, {nm, " R7 rounds"}, rounds, exp_rounds);
    chk(act_idx == 6 * exp_rounds, {nm, " R1 act count"}, act_idx, 6 * exp_rounds);
    chk(bank_o == bank_i, {nm, " R1 bank"}, bank_o, bank_i);
  endtask

  task automatic t_reset();
    chk(cmd_o == K_NOP, "R11 reset cmd", cmd_o, K_NOP);
    chk(done_o == 1'b0, "R11 reset done", done_o, 0);
    chk(rn_o == '0, "R11 reset word", rn_o, 0);
  endtask

  task automatic t_full();            // R2/R3 defaults, one round
    load_weights(0);
    run_req("full", 1, 0);
  endtask

  task automatic t_sparse();          // R5 zero weights skipped, R7 two rounds
    load_weights(1);
    set_tm(3, 2, 5);
    run_req("sparse", 2, 0);
  endtask

  task automatic t_wrap();            // R6 fold wraps four times
    load_weights(2);
    set_tm(2, 4, 7);
    run_req("wrap", 2, 0);
  endtask

  task automatic t_zero_gaps();       // R2 R3 zero acts as one
    load_weights(0);
    set_tm(0, 0, 0);
    run_req("zero", 1, 0);
  endtask

  task automatic t_restart_ignored(); // R9
    load_weights(0);
    set_tm(1, 1, 10);
    run_req("busy start R9", 1, 20);
  endtask

  task automatic t_abort();           // R10
    int dc;
    model_clear();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (12) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    chk(cmd_o == K_PRE, "R10 abort pre", cmd_o, K_PRE);
    @(negedge clk);
    chk(cmd_o == K_NOP, "R10 idle after abort", cmd_o, K_NOP);
    repeat (30) @(negedge clk);
    dc = done_cnt;
    chk(dc == 0, "R10 no done", dc, 0);
    chk(cmd_o == K_NOP, "R10 still idle", cmd_o, K_NOP);
    run_req("after abort R10", 1, 0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) wmem[i] = 8'd0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_sparse();
    t_wrap();
    t_zero_gaps();
    t_restart_ignored();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule